// File: doc/BRIEF.md
# Source-Routed Crossbar Port Arbiter

This block is the switching core of a small circuit-switched crossbar with `NPORT` input ports and `NPORT` output ports. Each master opens a path by presenting a two-word header. The first word holds a chain of 3-bit exit codes in its low bits and a priority field in its top bits. The lowest code names the output to take at this switch. The switch forwards the first word with that code removed. It then passes the second word, which holds the destination address and the direction, without change. It waits for the destination's acknowledge on that output and relays it to the master. After that it streams data words until the master marks the last one with end-of-packet, which releases the path.

Every input runs a state machine with these states: IDLE, REJECT, WAIT, HDR2, ACKW and DATA. The transitions are:
- IDLE goes to REJECT on a header whose leading code is invalid.
- IDLE goes to WAIT on a valid header.
- REJECT returns to IDLE.
- WAIT goes to HDR2 when a grant arrives; the first word is forwarded in that cycle.
- HDR2 goes to ACKW once the second word is accepted.
- ACKW goes to DATA when the acknowledge returns.
- DATA returns to IDLE on end-of-packet.

Every output runs an arbiter with the states FREE and HELD. FREE goes to HELD when any input requests that output. HELD either regrants or returns to FREE at the cycle in which the granted packet ends. An input that loses stays in WAIT and competes again only at the next packet boundary.

Top module: `xbar_route_switch`

## Requirements
- R1: While reset is held, and afterwards until a header arrives, every `out_valid`, `in_ready`, `in_ack` and `in_nak` bit is 0.
- R2: A header whose leading code (bits [2:0]) is `NPORT` or larger, or equals the input's own index, gets a one-cycle `in_nak` together with `in_ready`. No output carries any word of that header.
- R3: An accepted first word appears only on the output named by its leading code. Bits [26:0] are shifted right by 3 with zero fill. Bit 27 and the priority field in bits [31:28] are unchanged.
- R4: The second header word appears on the same output, unchanged, after the first word.
- R5: The destination's `out_ack` is relayed as exactly one `in_ack` pulse on the owning input. No data word reaches the output before that acknowledge.
- R6: Data words pass in order and unchanged. `out_eop` is set only on the word the master marked as last and implies `out_valid`, and that word ends the path.
- R7: When inputs contend for a free output, the one with the larger priority field is served first. The other is served after it.
- R8: On equal priority, the higher-numbered input is served first.
- R9: A held path is never taken over mid-packet, even by a higher-priority request. A waiting input wins the path only at the end of the current packet.
- R10: While a path is held, that output carries only the owner's words. No output grants more than one input, and no input owns more than one output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT | Per-input word valid from the master |
| in_data | input | NPORT*WORD_W | Per-input word (header or data) |
| in_eop | input | NPORT | Per-input last-data-word mark |
| in_ready | output | NPORT | Word consumed by the switch this cycle |
| in_ack | output | NPORT | Relayed destination acknowledge |
| in_nak | output | NPORT | Route code rejected |
| out_valid | output | NPORT | Per-output word valid |
| out_data | output | NPORT*WORD_W | Per-output word |
| out_eop | output | NPORT | Per-output last-word mark |
| out_ack | input | NPORT | Acknowledge from the destination on each output |

## Verification
Every cycle, the assertions check the following:
- a grant never has two owners, either per output or per input;
- a held grant stays fixed until the owner's end-of-packet;
- acknowledge and reject pulses last one cycle and never coincide;
- `out_eop` never appears without `out_valid`.

Which input wins a contended output, the route-code shift, the cycle order of acknowledge and first data word, and the behaviour after a rejected header can only be seen from the bench's scenarios. The bench shows them by logging what each output carries.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [2:0] {
        IN_IDLE,
        IN_REJECT,
        IN_WAIT,
        IN_HDR2,
        IN_ACKW,
        IN_DATA
    } in_state_t;

    typedef enum logic {
        OUT_FREE,
        OUT_HELD
    } out_state_t;
endpackage

// File: rtl/xbar_in_ctl.sv
module xbar_in_ctl
    import xbar_pkg::*;
#(
    parameter int NPORT  = 6,
    parameter int WORD_W = 32,
    parameter int HOPS   = 9,
    parameter int PRIO_W = 4,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    input  logic              in_eop,
    output logic              in_ready,
    output logic              in_ack,
    output logic              in_nak,
    output logic              req,
    output logic [CODE_W-1:0] req_port,
    output logic [PRIO_W-1:0] req_prio,
    input  logic              granted,
    input  logic              ack_back,
    output logic              fwd_valid,
    output logic [WORD_W-1:0] fwd_data,
    output logic              fwd_eop,
    output logic              pkt_end
);
    localparam int ROUTE_W = HOPS * CODE_W;

    in_state_t         state_q, state_d;
    logic              bad_code;
    logic [WORD_W-1:0] hop_word;

    assign req_port = in_data[CODE_W-1:0];
    assign req_prio = in_data[WORD_W-1 -: PRIO_W];
    assign bad_code = (int'(req_port) >= NPORT) || (int'(req_port) == IDX);

    // consume the leading exit code, keep every other bit of the word
    always_comb begin
        hop_word = in_data;
        hop_word[ROUTE_W-1:0] = {CODE_W'(0), in_data[ROUTE_W-1:CODE_W]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        in_ack    = 1'b0;
        in_nak    = 1'b0;
        req       = 1'b0;
        fwd_valid = 1'b0;
        fwd_data  = in_data;
        fwd_eop   = 1'b0;
        pkt_end   = 1'b0;
        unique case (state_q)
            IN_IDLE: begin
                if (in_valid) state_d = bad_code ? IN_REJECT : IN_WAIT;
            end
            IN_REJECT: begin
                in_nak   = 1'b1;
                in_ready = 1'b1;
                state_d  = IN_IDLE;
            end
            IN_WAIT: begin
                req = 1'b1;
                if (granted) begin
                    fwd_valid = 1'b1;
                    fwd_data  = hop_word;
                    in_ready  = 1'b1;
                    state_d   = IN_HDR2;
                end
            end
            IN_HDR2: begin
                in_ready  = 1'b1;
                fwd_valid = in_valid;
                if (in_valid) state_d = IN_ACKW;
            end
            IN_ACKW: begin
                if (ack_back) begin
                    in_ack  = 1'b1;
                    state_d = IN_DATA;
                end
            end
            IN_DATA: begin
                in_ready  = 1'b1;
                fwd_valid = in_valid;
                fwd_eop   = in_valid && in_eop;
                if (in_valid && in_eop) begin
                    pkt_end = 1'b1;
                    state_d = IN_IDLE;
                end
            end
            default: state_d = IN_IDLE;
        endcase
    end
endmodule

// File: rtl/xbar_out_arb.sv
module xbar_out_arb
    import xbar_pkg::*;
#(
    parameter int NPORT  = 6,
    parameter int PRIO_W = 4,
    parameter int OIDX   = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORT-1:0]         req,
    input  logic [NPORT*CODE_W-1:0]  req_port_flat,
    input  logic [NPORT*PRIO_W-1:0]  req_prio_flat,
    input  logic [NPORT-1:0]         pkt_end,
    output logic [NPORT-1:0]         grant
);
    out_state_t        state_q, state_d;
    logic [NPORT-1:0]  grant_d, pick;
    logic              found;
    logic [PRIO_W-1:0] best;

    // highest priority wins; ">=" lets a later (higher) index win a tie
    always_comb begin
        pick  = '0;
        found = 1'b0;
        best  = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (req[i] && int'(req_port_flat[i*CODE_W +: CODE_W]) == OIDX &&
                (!found || req_prio_flat[i*PRIO_W +: PRIO_W] >= best)) begin
                found   = 1'b1;
                best    = req_prio_flat[i*PRIO_W +: PRIO_W];
                pick    = '0;
                pick[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OUT_FREE;
            grant   <= '0;
        end else begin
            state_q <= state_d;
            grant   <= grant_d;
        end
    end

    always_comb begin
        state_d = state_q;
        grant_d = grant;
        unique case (state_q)
            OUT_FREE: begin
                if (found) begin
                    grant_d = pick;
                    state_d = OUT_HELD;
                end
            end
            OUT_HELD: begin
                if (|(grant & pkt_end)) begin
                    grant_d = pick;
                    state_d = found ? OUT_HELD : OUT_FREE;
                end
            end
            default: begin
                grant_d = '0;
                state_d = OUT_FREE;
            end
        endcase
    end
endmodule

// File: rtl/xbar_route_switch.sv
module xbar_route_switch
    import xbar_pkg::*;
#(
    parameter int NPORT  = 6,
    parameter int WORD_W = 32,
    parameter int HOPS   = 9,
    parameter int PRIO_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPORT-1:0]        in_valid,
    input  logic [NPORT*WORD_W-1:0] in_data,
    input  logic [NPORT-1:0]        in_eop,
    output logic [NPORT-1:0]        in_ready,
    output logic [NPORT-1:0]        in_ack,
    output logic [NPORT-1:0]        in_nak,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT*WORD_W-1:0] out_data,
    output logic [NPORT-1:0]        out_eop,
    input  logic [NPORT-1:0]        out_ack
);
    logic [NPORT-1:0]          req, granted, ack_back, fwd_valid, fwd_eop, pkt_end;
    logic [NPORT*CODE_W-1:0]   req_port_flat;
    logic [NPORT*PRIO_W-1:0]   req_prio_flat;
    logic [WORD_W-1:0]         fwd_data [NPORT];
    logic [NPORT-1:0]          grant [NPORT];
    logic [NPORT*NPORT-1:0]    grant_flat;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        xbar_in_ctl #(
            .NPORT(NPORT), .WORD_W(WORD_W), .HOPS(HOPS), .PRIO_W(PRIO_W), .IDX(i)
        ) u_in (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid[i]),
            .in_data  (in_data[i*WORD_W +: WORD_W]),
            .in_eop   (in_eop[i]),
            .in_ready (in_ready[i]),
            .in_ack   (in_ack[i]),
            .in_nak   (in_nak[i]),
            .req      (req[i]),
            .req_port (req_port_flat[i*CODE_W +: CODE_W]),
            .req_prio (req_prio_flat[i*PRIO_W +: PRIO_W]),
            .granted  (granted[i]),
            .ack_back (ack_back[i]),
            .fwd_valid(fwd_valid[i]),
            .fwd_data (fwd_data[i]),
            .fwd_eop  (fwd_eop[i]),
            .pkt_end  (pkt_end[i])
        );
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        xbar_out_arb #(
            .NPORT(NPORT), .PRIO_W(PRIO_W), .OIDX(o)
        ) u_arb (
            .clk          (clk),
            .rst_n        (rst_n),
            .req          (req),
            .req_port_flat(req_port_flat),
            .req_prio_flat(req_prio_flat),
            .pkt_end      (pkt_end),
            .grant        (grant[o])
        );
        assign grant_flat[o*NPORT +: NPORT] = grant[o];
    end

    // crossbar: each output follows its granted input, acks flow back
    always_comb begin
        out_valid = '0;
        out_eop   = '0;
        out_data  = '0;
        granted   = '0;
        ack_back  = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                if (grant[o][i]) begin
                    out_valid[o] = out_valid[o] | fwd_valid[i];
                    out_eop[o]   = out_eop[o] | fwd_eop[i];
                    out_data[o*WORD_W +: WORD_W] = out_data[o*WORD_W +: WORD_W] | fwd_data[i];
                    granted[i]   = 1'b1;
                    ack_back[i]  = ack_back[i] | out_ack[o];
                end
            end
        end
    end
endmodule

// File: rtl/xbar_route_switch_chk.sv
module xbar_route_switch_chk #(
    parameter int NPORT = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPORT-1:0]       in_ack,
    input logic [NPORT-1:0]       in_nak,
    input logic [NPORT-1:0]       out_valid,
    input logic [NPORT-1:0]       out_eop,
    input logic [NPORT-1:0]       out_ack,
    input logic [NPORT*NPORT-1:0] grant_flat
);
    logic [NPORT-1:0] by_out [NPORT];
    logic [NPORT-1:0] by_in  [NPORT];

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            by_out[o] = grant_flat[o*NPORT +: NPORT];
            for (int i = 0; i < NPORT; i++) by_in[i][o] = grant_flat[o*NPORT + i];
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_chk
        assert_nak_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
            in_nak[g] |=> !in_nak[g]);
        assert_nak_not_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !(in_nak[g] && in_ack[g]));
        assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
            in_ack[g] |=> !in_ack[g]);
        assert_ack_from_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
            in_ack[g] |-> (|out_ack));
        assert_eop_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_eop[g] |-> out_valid[g]);
        assert_hold_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ((|by_out[g]) && !(out_valid[g] && out_eop[g])) |=> $stable(by_out[g]));
        assert_one_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(by_out[g]));
        assert_one_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(by_in[g]));
    end
endmodule

bind xbar_route_switch xbar_route_switch_chk #(.NPORT(NPORT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ack    (in_ack),
    .in_nak    (in_nak),
    .out_valid (out_valid),
    .out_eop   (out_eop),
    .out_ack   (out_ack),
    .grant_flat(grant_flat)
);

// File: tb/sim_xbar_route_switch.sv
module sim_xbar_route_switch;
    localparam int P  = 10;
    localparam int NP = 6;
    localparam int W  = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NP-1:0]     m_valid, m_eop;
    logic [W-1:0]      m_data [NP];
    logic [NP*W-1:0]   in_data;
    logic [NP-1:0]     in_ready, in_ack, in_nak, out_valid, out_eop;
    logic [NP*W-1:0]   out_data;
    logic [NP-1:0]     out_ack;

    int tests = 0, fails = 0, cyc = 0;

    logic [W-1:0] rx_word [NP][64];
    logic         rx_eop  [NP][64];
    int           rx_cyc  [NP][64];
    int           rx_n    [NP];
    int           pkt_w   [NP];
    int           ack_dly [NP];
    int           ack_cyc [NP];

    always_comb for (int i = 0; i < NP; i++) in_data[i*W +: W] = m_data[i];

    xbar_route_switch #(.NPORT(NP), .WORD_W(W), .HOPS(9), .PRIO_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(m_valid), .in_data(in_data), .in_eop(m_eop),
        .in_ready(in_ready), .in_ack(in_ack), .in_nak(in_nak), .out_valid(out_valid),
        .out_data(out_data), .out_eop(out_eop), .out_ack(out_ack)
    );

    initial forever #(P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // destination model: logs every output word, acks two samples after word two
    always @(negedge clk) begin
        #1;
        for (int o = 0; o < NP; o++) begin
            if (!rst_n) begin
                out_ack[o] = 1'b0; rx_n[o] = 0; pkt_w[o] = 0; ack_dly[o] = 0; ack_cyc[o] = 0;
            end else begin
                out_ack[o] = 1'b0;
                if (ack_dly[o] > 0) begin
                    ack_dly[o] = ack_dly[o] - 1;
                    if (ack_dly[o] == 0) begin out_ack[o] = 1'b1; ack_cyc[o] = cyc; end
                end
                if (out_valid[o]) begin
                    rx_word[o][rx_n[o]] = out_data[o*W +: W];
                    rx_eop[o][rx_n[o]]  = out_eop[o];
                    rx_cyc[o][rx_n[o]]  = cyc;
                    rx_n[o] = rx_n[o] + 1;
                    pkt_w[o] = pkt_w[o] + 1;
                    if (pkt_w[o] == 2) ack_dly[o] = 2;
                    if (out_eop[o]) pkt_w[o] = 0;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mk_h1(int prio, int dst, int nxt, int spare);
        return {4'(prio), 1'(spare), 27'((nxt << 3) | dst)};
    endfunction
    function automatic logic [W-1:0] hop(logic [W-1:0] h);
        logic [W-1:0] r = h;
        r[26:0] = h[26:0] >> 3;
        return r;
    endfunction
    function automatic logic [W-1:0] dword(int src, int k);
        return 32'hDA00_0000 | W'(src << 16) | W'(k);
    endfunction
    function automatic logic [W-1:0] hdr2(int src);
        return 32'h8000_0000 | W'(src << 8) | 32'h5;
    endfunction

    // call at a negedge; returns at a negedge
    task automatic send(input int src, input logic [W-1:0] w, input bit e, output bit nk);
        bit got;
        nk = 0;
        m_valid[src] = 1'b1; m_data[src] = w; m_eop[src] = e;
        forever begin
            #(P/4);
            got = in_ready[src];
            if (in_nak[src]) nk = 1;
            @(negedge clk);
            if (got) break;
        end
        m_valid[src] = 1'b0; m_eop[src] = 1'b0;
    endtask

    task automatic master(input int src, input logic [W-1:0] h1, input logic [W-1:0] h2,
                          input int n, output bit nk, output bit ak);
        bit got;
        ak = 0;
        send(src, h1, 1'b0, nk);
        if (nk) return;
        send(src, h2, 1'b0, nk);
        forever begin
            #(P/4);
            got = in_ack[src];
            @(negedge clk);
            if (got) break;
        end
        ak = 1;
        for (int k = 0; k < n; k++) send(src, dword(src, k), k == n - 1, nk);
    endtask

    // src, dst, prio, data words, further route codes, spare bit
    localparam int VEC [4][6] = '{
        '{0, 3, 2, 3, 'o4521, 0},
        '{5, 1, 7, 1, 'o7, 1},
        '{2, 5, 0, 4, 'o12345670, 0},
        '{4, 0, 9, 2, 0, 1}
    };

    int  base [NP];
    bit  nk, ak, nk2, ak2;

    task automatic snap();
        for (int o = 0; o < NP; o++) base[o] = rx_n[o];
    endtask

    initial begin
        rst_n = 1'b0; m_valid = '0; m_eop = '0;
        for (int i = 0; i < NP; i++) m_data[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 0 && in_ready == 0, "R1", "reset out_valid/in_ready",
              W'({out_valid, in_ready}), 0);
        check(in_ack == 0 && in_nak == 0, "R1", "reset ack/nak", W'({in_ack, in_nak}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(out_valid == 0 && in_ready == 0 && in_ack == 0 && in_nak == 0, "R1",
              "idle after reset", W'({out_valid, in_ready, in_ack, in_nak}), 0);
        @(negedge clk);

        // table walk: single transfers
        for (int v = 0; v < 4; v++) begin
            automatic int s = VEC[v][0], d = VEC[v][1], n = VEC[v][3];
            automatic logic [W-1:0] h1 = mk_h1(VEC[v][2], d, VEC[v][4], VEC[v][5]);
            automatic int others = 0;
            snap();
            master(s, h1, hdr2(s), n, nk, ak);
            repeat (3) @(negedge clk);
            check(ak && !nk, "R5", "ack relayed", W'({ak, nk}), 2);
            check(rx_n[d] - base[d] == 2 + n, "R6", "word count", W'(rx_n[d] - base[d]), W'(2 + n));
            check(rx_word[d][base[d]] == hop(h1), "R3", "shifted first word",
                  rx_word[d][base[d]], hop(h1));
            check(rx_word[d][base[d] + 1] == hdr2(s), "R4", "second word",
                  rx_word[d][base[d] + 1], hdr2(s));
            check(rx_cyc[d][base[d] + 2] > ack_cyc[d], "R5", "data after ack",
                  W'(rx_cyc[d][base[d] + 2]), W'(ack_cyc[d]));
            for (int k = 0; k < n; k++) begin
                check(rx_word[d][base[d] + 2 + k] == dword(s, k), "R6", "data word",
                      rx_word[d][base[d] + 2 + k], dword(s, k));
                check(rx_eop[d][base[d] + 2 + k] == (k == n - 1), "R6", "eop mark",
                      W'(rx_eop[d][base[d] + 2 + k]), W'(k == n - 1));
            end
            for (int o = 0; o < NP; o++) if (o != d) others += rx_n[o] - base[o];
            check(others == 0, "R3", "other outputs silent", W'(others), 0);
        end

        // reject: own port, nonexistent port
        snap();
        master(2, mk_h1(3, 2, 0, 0), hdr2(2), 1, nk, ak);
        check(nk && !ak, "R2", "own-port nak", W'({nk, ak}), 2);
        master(1, mk_h1(3, 7, 0, 0), hdr2(1), 1, nk, ak);
        check(nk && !ak, "R2", "bad-port nak", W'({nk, ak}), 2);
        repeat (3) @(negedge clk);
        begin
            automatic int moved = 0;
            for (int o = 0; o < NP; o++) moved += rx_n[o] - base[o];
            check(moved == 0, "R2", "no output words", W'(moved), 0);
        end

        // priority contention on output 2
        snap();
        fork
            master(1, mk_h1(3, 2, 0, 0), hdr2(1), 2, nk, ak);
            master(4, mk_h1(8, 2, 0, 0), hdr2(4), 3, nk2, ak2);
        join
        repeat (3) @(negedge clk);
        check(rx_word[2][base[2] + 1] == hdr2(4), "R7", "high prio first",
              rx_word[2][base[2] + 1], hdr2(4));
        check(rx_word[2][base[2] + 6] == hdr2(1), "R7", "low prio after",
              rx_word[2][base[2] + 6], hdr2(1));
        check(rx_word[2][base[2] + 4] == dword(4, 2), "R10", "owner words contiguous",
              rx_word[2][base[2] + 4], dword(4, 2));

        // equal priority on output 5
        snap();
        fork
            master(0, mk_h1(5, 5, 0, 0), hdr2(0), 1, nk, ak);
            master(3, mk_h1(5, 5, 0, 0), hdr2(3), 1, nk2, ak2);
        join
        repeat (3) @(negedge clk);
        check(rx_word[5][base[5] + 1] == hdr2(3), "R8", "tie to higher input",
              rx_word[5][base[5] + 1], hdr2(3));
        check(rx_word[5][base[5] + 4] == hdr2(0), "R8", "lower input after",
              rx_word[5][base[5] + 4], hdr2(0));

        // no preemption on output 4
        snap();
        fork
            master(0, mk_h1(1, 4, 0, 0), hdr2(0), 6, nk, ak);
            begin
                repeat (5) @(negedge clk);
                master(5, mk_h1(15, 4, 0, 0), hdr2(5), 1, nk2, ak2);
            end
        join
        repeat (3) @(negedge clk);
        check(rx_word[4][base[4] + 1] == hdr2(0), "R9", "holder first",
              rx_word[4][base[4] + 1], hdr2(0));
        check(rx_word[4][base[4] + 7] == dword(0, 5) && rx_eop[4][base[4] + 7], "R9",
              "holder finishes uninterrupted", rx_word[4][base[4] + 7], dword(0, 5));
        check(rx_word[4][base[4] + 9] == hdr2(5), "R9", "retry after eop",
              rx_word[4][base[4] + 9], hdr2(5));
        check(rx_n[4] - base[4] == 11, "R10", "two full packets", W'(rx_n[4] - base[4]), 11);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule